// File: doc/BRIEF.md
# High-Side Gate Shutdown and Edge Rearm Controller

This block sits between the commutation logic and the high-side gate drivers of a three-phase bridge. It passes each phase's high-side command through to its gate output, and removes it when any of three shutdown causes is active: a filtered shutdown request shared by all phases, a per-phase bootstrap supply-good flag, or a logic supply-good flag shared by all phases. After any shutdown a phase stays dark until its own command goes low and then high again. A command that was already high when the cause cleared can therefore never re-enable a gate.

The block also contains the current-limit detector. It raises a limit flag once the shunt comparator input has stayed high for a qualification time. In a current-limiting setup that flag is wired back to the shutdown request. A second, longer qualification filter on the request then turns the high-side gates off for the rest of the carrier period. Both filter lengths are parameters counted in clock cycles, and a length of zero selects a plain pass-through.

Top module: `hs_gate_ctrl`

## Requirements
- R1: While a phase is armed and no shutdown cause applies to it, its gate output equals its command input in the same cycle.
- R2: Reset leaves every phase disarmed, and every gate and the limit flag low. A command held high through reset does not turn its gate on: the command must first be sampled low and then high at clock edges after reset.
- R3: The shutdown request must be sampled high at SD_CYC consecutive clock edges before it takes effect. A request sampled high at SD_CYC-1 edges or fewer changes no gate. Once it is qualified, all gates are low from that edge until the request is sampled low.
- R4: When a shutdown cause clears, each affected phase keeps its gate low until its own command is sampled low and then high at two successive edges. Each phase rearms independently of the others.
- R5: A low bootstrap flag for a phase forces that phase's gate low in the same cycle and disarms it. Other phases are not affected.
- R6: A low logic-supply flag forces all gates low in the same cycle and disarms every phase.
- R7: The limit flag goes high after the sense comparator input has been sampled high at LIM_CYC consecutive edges. It goes low after the first edge that samples the comparator low.
- R8: A gate output is never high while its command input is low.
- R9: A rising command edge sampled while a cause is active for that phase does not arm it. The phase stays off after the cause clears until it sees a fresh edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd | input | NPH | High-side command per phase, active high |
| shut_req | input | 1 | Shared high-side shutdown request, active high, before filtering |
| boot_ok | input | NPH | Per-phase bootstrap supply good, high when above threshold |
| logic_sup_ok | input | 1 | Logic supply good, high when above threshold |
| isense_hi | input | 1 | Shunt sense comparator output, high when over limit |
| ilim_flag | output | 1 | Qualified current-limit flag |
| hs_gate | output | NPH | High-side gate enables, active high |

## Verification
The assertions check on every cycle that no gate is high while its command is low, while the logic supply is bad, while its bootstrap flag is low, or while the filtered shutdown is active. They also check that a gate only rises after its command has been low at one of the two previous edges, and that the limit flag never outlives a low comparator sample. Only the bench scenarios can show the counted thresholds: the exact edge at which a shutdown or limit qualifies, and that a pulse one edge short does nothing. They also show that arming is refused while a cause is active, and that rearming is independent per phase across random mixes of commands, supply drops and limit bursts.

// File: rtl/hs_pkg.sv
package hs_pkg;

   typedef enum logic {
      PH_DISARMED = 1'b0,
      PH_ARMED    = 1'b1
   } arm_e;

   // bits needed to hold the value n
   function automatic int cnt_bits(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/hs_qual_filt.sv
module hs_qual_filt #(
   parameter int unsigned CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (CYC == 0) begin : g_thru
         assign dout = din;
      end else begin : g_cnt
         localparam int W = hs_pkg::cnt_bits(CYC);
         localparam logic [W-1:0] TOP = W'(CYC);
         logic [W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!din)          cnt_q <= '0;
            else if (cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
         end

         assign dout = (cnt_q == TOP);
      end
   endgenerate
endmodule

// File: rtl/hs_phase_arm.sv
module hs_phase_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd,
   input  logic kill,
   output logic gate
);
   import hs_pkg::*;

   logic cmd_q;
   arm_e st_q;

   // cmd_q resets high so a command held through reset is not an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= 1'b1;
         st_q  <= PH_DISARMED;
      end else begin
         cmd_q <= cmd;
         if (kill)              st_q <= PH_DISARMED;
         else if (cmd && !cmd_q) st_q <= PH_ARMED;
      end
   end

   assign gate = (st_q == PH_ARMED) && cmd && !kill;
endmodule

// File: rtl/hs_gate_ctrl.sv
module hs_gate_ctrl #(
   parameter int unsigned NPH     = 3,
   parameter int unsigned SD_CYC  = 825,
   parameter int unsigned LIM_CYC = 500
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NPH-1:0] hs_cmd,
   input  logic           shut_req,
   input  logic [NPH-1:0] boot_ok,
   input  logic           logic_sup_ok,
   input  logic           isense_hi,
   output logic           ilim_flag,
   output logic [NPH-1:0] hs_gate
);
   generate
      if (NPH < 1 || NPH > 16) begin : g_bad_nph
         $error("hs_gate_ctrl: NPH must be in 1..16");
      end
      if (SD_CYC > 1000000 || LIM_CYC > 1000000) begin : g_bad_cyc
         $error("hs_gate_ctrl: filter length out of range");
      end
   endgenerate

   logic sd_filt;

   hs_qual_filt #(.CYC(SD_CYC)) u_sd_filt (
      .clk (clk), .rst_n (rst_n), .din (shut_req), .dout (sd_filt)
   );

   hs_qual_filt #(.CYC(LIM_CYC)) u_lim_filt (
      .clk (clk), .rst_n (rst_n), .din (isense_hi), .dout (ilim_flag)
   );

   logic shared_kill;
   assign shared_kill = sd_filt || !logic_sup_ok;

   generate
      for (genvar p = 0; p < int'(NPH); p++) begin : g_ph
         hs_phase_arm u_arm (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (hs_cmd[p]),
            .kill  (shared_kill || !boot_ok[p]),
            .gate  (hs_gate[p])
         );
      end
   endgenerate
endmodule

// File: rtl/hs_gate_chk.sv
module hs_gate_chk #(
   parameter int unsigned NPH = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NPH-1:0] hs_cmd,
   input logic [NPH-1:0] boot_ok,
   input logic           logic_sup_ok,
   input logic           isense_hi,
   input logic           sd_filt,
   input logic           ilim_flag,
   input logic [NPH-1:0] hs_gate
);
   assert_follow_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_gate & ~hs_cmd) == '0);

   assert_logic_sup_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !logic_sup_ok |-> hs_gate == '0);

   assert_boot_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_gate & ~boot_ok) == '0);

   assert_shutdown_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sd_filt |-> hs_gate == '0);

   assert_lim_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !isense_hi |=> !ilim_flag);

   assert_lim_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ilim_flag) |-> $past(isense_hi));

   generate
      for (genvar p = 0; p < int'(NPH); p++) begin : g_ph
         assert_rearm_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hs_gate[p]) |-> (!$past(hs_cmd[p]) || !$past(hs_cmd[p], 2)));
      end
   endgenerate
endmodule

bind hs_gate_ctrl hs_gate_chk #(.NPH(NPH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .hs_cmd       (hs_cmd),
   .boot_ok      (boot_ok),
   .logic_sup_ok (logic_sup_ok),
   .isense_hi    (isense_hi),
   .sd_filt      (sd_filt),
   .ilim_flag    (ilim_flag),
   .hs_gate      (hs_gate)
);

// File: tb/sim_hs_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hs_gate_ctrl;
   localparam int NPH = 3;
   localparam int SD  = 825;
   localparam int LIM = 500;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NPH-1:0] hs_cmd = '0;
   logic           shut_req = 1'b0;
   logic [NPH-1:0] boot_ok = '1;
   logic           logic_sup_ok = 1'b1;
   logic           isense_hi = 1'b0;
   logic           ilim_flag;
   logic [NPH-1:0] hs_gate;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;
   string cur_req = "R2";

   always #2 clk = ~clk;

   hs_gate_ctrl #(.NPH(NPH), .SD_CYC(SD), .LIM_CYC(LIM)) u0 (
      .clk (clk), .rst_n (rst_n), .hs_cmd (hs_cmd), .shut_req (shut_req),
      .boot_ok (boot_ok), .logic_sup_ok (logic_sup_ok), .isense_hi (isense_hi),
      .ilim_flag (ilim_flag), .hs_gate (hs_gate)
   );

   // reference model built from the requirements
   int m_sdc, m_limc;
   logic [NPH-1:0] m_cq, m_arm;

   function automatic logic [NPH-1:0] exp_gate();
      logic [NPH-1:0] g;
      for (int i = 0; i < NPH; i++)
         g[i] = m_arm[i] & hs_cmd[i] & ~((m_sdc == SD) | ~logic_sup_ok | ~boot_ok[i]);
      return g;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sdc <= 0; m_limc <= 0; m_cq <= '1; m_arm <= '0;
      end else begin
         m_sdc  <= shut_req  ? ((m_sdc  < SD)  ? m_sdc + 1  : m_sdc)  : 0;
         m_limc <= isense_hi ? ((m_limc < LIM) ? m_limc + 1 : m_limc) : 0;
         for (int i = 0; i < NPH; i++) begin
            if ((m_sdc == SD) || !logic_sup_ok || !boot_ok[i]) m_arm[i] <= 1'b0;
            else if (hs_cmd[i] && !m_cq[i])                   m_arm[i] <= 1'b1;
         end
         m_cq <= hs_cmd;
      end
   end

   task automatic model_chk();
      checks++;
      if (hs_gate !== exp_gate()) begin
         errors++;
         $display("FAIL %s gate actual=%b expected=%b t=%0t", cur_req, hs_gate, exp_gate(), $time);
      end
      checks++;
      if (ilim_flag !== (m_limc == LIM)) begin
         errors++;
         $display("FAIL %s limit actual=%b expected=%b t=%0t", cur_req, ilim_flag, (m_limc == LIM), $time);
      end
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         model_chk();
      end
   endtask

   task automatic expect_gate(input logic [NPH-1:0] e, input string req);
      checks++;
      if (hs_gate !== e) begin
         errors++;
         $display("FAIL %s directed gate actual=%b expected=%b t=%0t", req, hs_gate, e, $time);
      end
   endtask

   task automatic expect_lim(input logic e, input string req);
      checks++;
      if (ilim_flag !== e) begin
         errors++;
         $display("FAIL %s directed limit actual=%b expected=%b t=%0t", req, ilim_flag, e, $time);
      end
   endtask

   task automatic rearm_all();
      hs_cmd = '0; step(1);
      hs_cmd = '1; step(1);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int sd_left, lim_left, vb_left, vl_left;
      void'($urandom(32'd5150));

      // R2: reset state with commands already high
      hs_cmd = '1;
      #1;
      @(negedge clk);
      expect_gate('0, "R2");
      expect_lim(1'b0, "R2");
      step(2);
      rst_n = 1'b1;
      cur_req = "R2";
      step(5);
      expect_gate('0, "R2");

      // R1: low then high arms
      hs_cmd = '0; step(1);
      hs_cmd = 3'b101; step(1);
      cur_req = "R1";
      expect_gate(3'b101, "R1");
      hs_cmd = 3'b111; step(1);
      expect_gate(3'b111, "R1");
      hs_cmd = 3'b010; step(1);
      expect_gate(3'b010, "R8");
      hs_cmd = 3'b111; step(1);
      expect_gate(3'b111, "R1");

      // R3: request one edge short is ignored
      cur_req = "R3";
      shut_req = 1'b1; step(SD - 1);
      expect_gate(3'b111, "R3");
      shut_req = 1'b0; step(1);
      expect_gate(3'b111, "R3");
      shut_req = 1'b1; step(SD);
      expect_gate(3'b000, "R3");
      step(4);
      expect_gate(3'b000, "R3");
      shut_req = 1'b0; step(1);

      // R4: stale high commands stay off, per-phase rearm
      cur_req = "R4";
      expect_gate(3'b000, "R4");
      step(3);
      expect_gate(3'b000, "R4");
      hs_cmd = 3'b110; step(1);
      expect_gate(3'b000, "R4");
      hs_cmd = 3'b011; step(1);
      expect_gate(3'b001, "R4");
      hs_cmd = 3'b111; step(1);
      expect_gate(3'b101, "R4");
      hs_cmd = 3'b101; step(1);
      hs_cmd = 3'b111; step(1);
      expect_gate(3'b111, "R4");

      // R5: single-phase bootstrap drop
      cur_req = "R5";
      boot_ok = 3'b101; #1;
      expect_gate(3'b101, "R5");
      step(2);
      boot_ok = 3'b111; step(2);
      expect_gate(3'b101, "R5");
      hs_cmd = 3'b101; step(1);
      hs_cmd = 3'b111; step(1);
      expect_gate(3'b111, "R5");

      // R6: logic supply drop kills all
      cur_req = "R6";
      logic_sup_ok = 1'b0; #1;
      expect_gate(3'b000, "R6");
      step(3);
      logic_sup_ok = 1'b1; step(2);
      expect_gate(3'b000, "R6");
      rearm_all();
      expect_gate(3'b111, "R6");

      // R9: edge during a cause does not arm
      cur_req = "R9";
      boot_ok = 3'b110;
      hs_cmd = 3'b110; step(1);
      hs_cmd = 3'b111; step(1);
      expect_gate(3'b110, "R9");
      boot_ok = 3'b111; step(2);
      expect_gate(3'b110, "R9");
      hs_cmd = 3'b110; step(1);
      hs_cmd = 3'b111; step(1);
      expect_gate(3'b111, "R9");

      // R7: limit qualification
      cur_req = "R7";
      isense_hi = 1'b1; step(LIM - 1);
      expect_lim(1'b0, "R7");
      step(1);
      expect_lim(1'b1, "R7");
      step(3);
      expect_lim(1'b1, "R7");
      isense_hi = 1'b0; step(1);
      expect_lim(1'b0, "R7");
      isense_hi = 1'b1; step(20);
      expect_lim(1'b0, "R7");
      isense_hi = 1'b0; step(1);

      // random mix, checked against the model every cycle
      cur_req = "R1";
      sd_left = 0; lim_left = 0; vb_left = 0; vl_left = 0;
      for (int n = 0; n < 20000; n++) begin
         for (int i = 0; i < NPH; i++)
            if ($urandom_range(7) == 0) hs_cmd[i] = ~hs_cmd[i];
         if (sd_left > 0) sd_left--;
         else if ($urandom_range(999) == 0) sd_left = $urandom_range(1200, 1);
         shut_req = (sd_left > 0);
         if (lim_left > 0) lim_left--;
         else if ($urandom_range(199) == 0) lim_left = $urandom_range(700, 1);
         isense_hi = (lim_left > 0);
         if (vb_left > 0) vb_left--;
         else if ($urandom_range(299) == 0) begin
            vb_left = $urandom_range(40, 1);
            boot_ok = NPH'($urandom_range(6));
         end
         if (vb_left == 0) boot_ok = '1;
         if (vl_left > 0) vl_left--;
         else if ($urandom_range(799) == 0) vl_left = $urandom_range(30, 1);
         logic_sup_ok = (vl_left == 0);
         step(1);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule